// File: doc/BRIEF.md
# High-Speed Isochronous Transaction Record Selector

This block sits between the local copy of one high-speed isochronous transfer descriptor and the transaction engine. It is given the eight transaction records of the descriptor, the buffer page pointer array and the endpoint fields. A start pulse carries the current micro-frame number. The block then uses that number to pick one record. If the record is armed, it issues one execute strobe with the starting buffer address, the clipped transfer length, the token fields and the direction. Bus packet generation and the memory fetch belong to other blocks.

After the engine reports how many bytes moved and which error conditions came up, the block forms the write-back values for the same record: the remaining length and a new status nibble with the active flag cleared. The owner of the descriptor storage applies them. From the execute strobe until the completion report, the block counts as busy and ignores any new start.

Top module: `iso_rec_sel`

## Requirements
- R1: The 3-bit micro-frame number given with the start pulse picks the record of that index, so a value of 2 uses record 2. Record k sits at bits [k*12 +: 12] of the length and offset buses, bits [k*3 +: 3] of the page-select bus and bit k of the active vector.
- R2: An execute strobe is raised only when the chosen record's active bit is 1. An inactive record produces no strobe and no error, and the block stays idle.
- R3: The start address is page pointer p (20 bits, taken from bits [p*20 +: 20] of the page bus, with p the record's page select) in the upper bits, followed by the record's 12-bit offset in the lower bits.
- R4: The transfer length is the smaller of the record's length and the zero-extended max packet size.
- R5: With the execute strobe, the token endpoint, device address and direction (1 = IN) outputs carry the values present at the start pulse.
- R6: On completion, the write-back length is the chosen record's length minus the reported byte count, floored at zero.
- R7: The write-back status is 4 bits: bit 0 is the active flag, always 0, and bits [3:1] copy the 3-bit completion error flags. The write-back index equals the selected record.
- R8: If an active record's page select is above 6, the block raises a page error pulse instead of an execute strobe and stays idle.
- R9: A start pulse while busy is ignored, and a completion report while idle is ignored.
- R10: Execute and page error pulses appear in the cycle after the start pulse, and the write-back pulse appears in the cycle after the completion report. Each pulse lasts one cycle, and busy is high from the execute strobe until the write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Evaluate the record for this micro-frame |
| uframe_i | input | 3 | Micro-frame number |
| rec_active_i | input | 8 | Active bit per record |
| rec_len_i | input | 96 | Transaction length per record |
| rec_off_i | input | 96 | 12-bit buffer offset per record |
| rec_pg_i | input | 24 | Page select per record |
| page_ptr_i | input | 140 | Seven 20-bit buffer page pointers |
| max_pkt_i | input | 11 | Max packet size |
| ep_i | input | 4 | Endpoint number |
| dev_i | input | 7 | Device address |
| dir_in_i | input | 1 | Direction, 1 = IN |
| done_i | input | 1 | Completion report valid |
| done_bytes_i | input | 12 | Bytes moved |
| done_err_i | input | 3 | Error flags from the transaction |
| busy_o | output | 1 | A transaction is outstanding |
| exec_o | output | 1 | Execute strobe |
| exec_addr_o | output | 32 | Start buffer address |
| exec_len_o | output | 12 | Transfer length |
| tok_ep_o | output | 4 | Token endpoint |
| tok_dev_o | output | 7 | Token device address |
| dir_in_o | output | 1 | Transfer direction |
| page_err_o | output | 1 | Page select out of range |
| wb_o | output | 1 | Write-back valid |
| wb_idx_o | output | 3 | Record being written back |
| wb_len_o | output | 12 | Remaining length |
| wb_status_o | output | 4 | New status nibble |

## Verification
The hardest case to reach from the ports is a second start pulse that arrives while a transaction is still outstanding and points at a different active record. The completion must then be written back to the first record, using the first record's length. The stimulus starts a transaction, holds back the completion, issues a start for another armed micro-frame, and checks that no second strobe appears and that the write-back index and length belong to the first record. Byte counts larger than the record length are also sent so that the floor at zero is exercised.

// File: rtl/iso_rec_pkg.sv
package iso_rec_pkg;
    localparam int NREC   = 8;
    localparam int IDX_W  = $clog2(NREC);
    localparam int NPAGE  = 7;
    localparam int PG_W   = 3;
    localparam int PTR_W  = 20;
    localparam int OFF_W  = 12;
    localparam int ADDR_W = PTR_W + OFF_W;
    localparam int LEN_W  = 12;
    localparam int MPS_W  = 11;
    localparam int EP_W   = 4;
    localparam int DEV_W  = 7;
    localparam int ERR_W  = 3;
    localparam int STAT_W = ERR_W + 1;

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [LEN_W-1:0]  rec_len;
        logic              exec;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  xlen;
        logic [EP_W-1:0]   ep;
        logic [DEV_W-1:0]  dev;
        logic              dir_in;
        logic              pg_err;
        logic              wb;
        logic [IDX_W-1:0]  wb_idx;
        logic [LEN_W-1:0]  wb_len;
        logic [STAT_W-1:0] wb_stat;
    } sel_state_t;
endpackage

// File: rtl/iso_rec_mux.sv
module iso_rec_mux #(
    parameter int NREC  = 8,
    parameter int LEN_W = 12,
    parameter int OFF_W = 12,
    parameter int PG_W  = 3,
    localparam int IDX_W = $clog2(NREC)
) (
    input  logic [NREC-1:0]       act_i,
    input  logic [NREC*LEN_W-1:0] len_i,
    input  logic [NREC*OFF_W-1:0] off_i,
    input  logic [NREC*PG_W-1:0]  pg_i,
    input  logic [IDX_W-1:0]      idx_i,
    output logic                  act_o,
    output logic [LEN_W-1:0]      len_o,
    output logic [OFF_W-1:0]      off_o,
    output logic [PG_W-1:0]       pg_o
);
    logic [LEN_W-1:0] len_a [NREC];
    logic [OFF_W-1:0] off_a [NREC];
    logic [PG_W-1:0]  pg_a  [NREC];

    for (genvar k = 0; k < NREC; k++) begin : g_unpack
        assign len_a[k] = len_i[k*LEN_W +: LEN_W];
        assign off_a[k] = off_i[k*OFF_W +: OFF_W];
        assign pg_a[k]  = pg_i[k*PG_W +: PG_W];
    end

    assign act_o = act_i[idx_i];
    assign len_o = len_a[idx_i];
    assign off_o = off_a[idx_i];
    assign pg_o  = pg_a[idx_i];
endmodule

// File: rtl/iso_addr_form.sv
module iso_addr_form #(
    parameter int NPAGE = 7,
    parameter int PG_W  = 3,
    parameter int PTR_W = 20,
    parameter int OFF_W = 12,
    parameter int LEN_W = 12,
    parameter int MPS_W = 11,
    localparam int ADDR_W = PTR_W + OFF_W
) (
    input  logic [NPAGE*PTR_W-1:0] page_i,
    input  logic [PG_W-1:0]        pg_i,
    input  logic [OFF_W-1:0]       off_i,
    input  logic [LEN_W-1:0]       len_i,
    input  logic [MPS_W-1:0]       mps_i,
    output logic [ADDR_W-1:0]      addr_o,
    output logic [LEN_W-1:0]       xlen_o,
    output logic                   pg_bad_o
);
    logic [PTR_W-1:0] ptr_a [NPAGE];
    logic [PTR_W-1:0] ptr_sel;
    logic [LEN_W-1:0] mps_ext;

    for (genvar p = 0; p < NPAGE; p++) begin : g_page
        assign ptr_a[p] = page_i[p*PTR_W +: PTR_W];
    end

    always_comb begin
        ptr_sel = '0;
        for (int p = 0; p < NPAGE; p++) begin
            if (int'(pg_i) == p) ptr_sel = ptr_a[p];
        end
    end

    assign pg_bad_o = int'(pg_i) >= NPAGE;
    assign addr_o   = {ptr_sel, off_i};
    assign mps_ext  = LEN_W'(mps_i);
    assign xlen_o   = (len_i < mps_ext) ? len_i : mps_ext;
endmodule

// File: rtl/iso_wb_calc.sv
module iso_wb_calc #(
    parameter int LEN_W = 12,
    parameter int ERR_W = 3,
    localparam int STAT_W = ERR_W + 1
) (
    input  logic [LEN_W-1:0]  len_i,
    input  logic [LEN_W-1:0]  bytes_i,
    input  logic [ERR_W-1:0]  err_i,
    output logic [LEN_W-1:0]  len_o,
    output logic [STAT_W-1:0] stat_o
);
    assign len_o  = (bytes_i >= len_i) ? '0 : (len_i - bytes_i);
    assign stat_o = {err_i, 1'b0};
endmodule

// File: rtl/iso_rec_sel.sv
module iso_rec_sel
    import iso_rec_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_i,
    input  logic [IDX_W-1:0]        uframe_i,
    input  logic [NREC-1:0]         rec_active_i,
    input  logic [NREC*LEN_W-1:0]   rec_len_i,
    input  logic [NREC*OFF_W-1:0]   rec_off_i,
    input  logic [NREC*PG_W-1:0]    rec_pg_i,
    input  logic [NPAGE*PTR_W-1:0]  page_ptr_i,
    input  logic [MPS_W-1:0]        max_pkt_i,
    input  logic [EP_W-1:0]         ep_i,
    input  logic [DEV_W-1:0]        dev_i,
    input  logic                    dir_in_i,
    input  logic                    done_i,
    input  logic [LEN_W-1:0]        done_bytes_i,
    input  logic [ERR_W-1:0]        done_err_i,
    output logic                    busy_o,
    output logic                    exec_o,
    output logic [ADDR_W-1:0]       exec_addr_o,
    output logic [LEN_W-1:0]        exec_len_o,
    output logic [EP_W-1:0]         tok_ep_o,
    output logic [DEV_W-1:0]        tok_dev_o,
    output logic                    dir_in_o,
    output logic                    page_err_o,
    output logic                    wb_o,
    output logic [IDX_W-1:0]        wb_idx_o,
    output logic [LEN_W-1:0]        wb_len_o,
    output logic [STAT_W-1:0]       wb_status_o
);
    sel_state_t st_d, st_q;

    logic              sel_act;
    logic [LEN_W-1:0]  sel_len;
    logic [OFF_W-1:0]  sel_off;
    logic [PG_W-1:0]   sel_pg;
    logic [ADDR_W-1:0] f_addr;
    logic [LEN_W-1:0]  f_xlen;
    logic              f_pg_bad;
    logic [LEN_W-1:0]  w_len;
    logic [STAT_W-1:0] w_stat;

    iso_rec_mux #(
        .NREC (NREC), .LEN_W(LEN_W), .OFF_W(OFF_W), .PG_W(PG_W)
    ) u_mux (
        .act_i (rec_active_i), .len_i(rec_len_i), .off_i(rec_off_i),
        .pg_i  (rec_pg_i),     .idx_i(uframe_i),
        .act_o (sel_act),      .len_o(sel_len),   .off_o(sel_off),
        .pg_o  (sel_pg)
    );

    iso_addr_form #(
        .NPAGE(NPAGE), .PG_W(PG_W), .PTR_W(PTR_W), .OFF_W(OFF_W),
        .LEN_W(LEN_W), .MPS_W(MPS_W)
    ) u_addr (
        .page_i (page_ptr_i), .pg_i(sel_pg), .off_i(sel_off),
        .len_i  (sel_len),    .mps_i(max_pkt_i),
        .addr_o (f_addr),     .xlen_o(f_xlen), .pg_bad_o(f_pg_bad)
    );

    iso_wb_calc #(
        .LEN_W(LEN_W), .ERR_W(ERR_W)
    ) u_wb (
        .len_i (st_q.rec_len), .bytes_i(done_bytes_i), .err_i(done_err_i),
        .len_o (w_len),        .stat_o(w_stat)
    );

    always_comb begin
        st_d        = st_q;
        st_d.exec   = 1'b0;
        st_d.pg_err = 1'b0;
        st_d.wb     = 1'b0;
        if (!st_q.busy) begin
            if (start_i && sel_act) begin
                if (f_pg_bad) begin
                    st_d.pg_err = 1'b1;
                end else begin
                    st_d.exec    = 1'b1;
                    st_d.busy    = 1'b1;
                    st_d.idx     = uframe_i;
                    st_d.rec_len = sel_len;
                    st_d.addr    = f_addr;
                    st_d.xlen    = f_xlen;
                    st_d.ep      = ep_i;
                    st_d.dev     = dev_i;
                    st_d.dir_in  = dir_in_i;
                end
            end
        end else if (done_i) begin
            st_d.busy    = 1'b0;
            st_d.wb      = 1'b1;
            st_d.wb_idx  = st_q.idx;
            st_d.wb_len  = w_len;
            st_d.wb_stat = w_stat;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o      = st_q.busy;
    assign exec_o      = st_q.exec;
    assign exec_addr_o = st_q.addr;
    assign exec_len_o  = st_q.xlen;
    assign tok_ep_o    = st_q.ep;
    assign tok_dev_o   = st_q.dev;
    assign dir_in_o    = st_q.dir_in;
    assign page_err_o  = st_q.pg_err;
    assign wb_o        = st_q.wb;
    assign wb_idx_o    = st_q.wb_idx;
    assign wb_len_o    = st_q.wb_len;
    assign wb_status_o = st_q.wb_stat;

    p_exec_after_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exec_o |-> $past(start_i) && busy_o);

    p_exec_needs_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exec_o |-> $past(rec_active_i[uframe_i]));

    p_len_clipped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exec_o |-> exec_len_o <= LEN_W'($past(max_pkt_i)));

    p_pgerr_no_exec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        page_err_o |-> !exec_o && !busy_o);

    p_wb_after_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wb_o |-> $past(done_i) && $past(busy_o) && !busy_o);

    p_wb_inactive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wb_o |-> !wb_status_o[0]);

    p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && !done_i |=> busy_o && !exec_o && !page_err_o);

    p_one_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({exec_o, page_err_o, wb_o}));
endmodule

// File: tb/iso_rec_sel_tb_top.sv
module iso_rec_sel_tb_top;
    import iso_rec_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                   start = 1'b0;
    logic [IDX_W-1:0]       uframe = '0;
    logic [NREC-1:0]        act_v;
    logic [NREC*LEN_W-1:0]  len_v;
    logic [NREC*OFF_W-1:0]  off_v;
    logic [NREC*PG_W-1:0]   pg_v;
    logic [NPAGE*PTR_W-1:0] page_v;
    logic [MPS_W-1:0]       mps = 11'd1024;
    logic [EP_W-1:0]        ep = 4'h5;
    logic [DEV_W-1:0]       dev = 7'h21;
    logic                   dir_in = 1'b1;
    logic                   done = 1'b0;
    logic [LEN_W-1:0]       dbytes = '0;
    logic [ERR_W-1:0]       derr = '0;

    logic                   busy, exec_s, dir_o, pg_err, wb;
    logic [ADDR_W-1:0]      addr;
    logic [LEN_W-1:0]       xlen, wb_len;
    logic [EP_W-1:0]        tep;
    logic [DEV_W-1:0]       tdev;
    logic [IDX_W-1:0]       wb_idx;
    logic [STAT_W-1:0]      wb_st;

    logic       m_act [NREC];
    int         m_len [NREC];
    int         m_off [NREC];
    int         m_pg  [NREC];
    logic [PTR_W-1:0] m_ptr [NPAGE];

    always_comb begin
        for (int k = 0; k < NREC; k++) begin
            act_v[k]                = m_act[k];
            len_v[k*LEN_W +: LEN_W] = LEN_W'(m_len[k]);
            off_v[k*OFF_W +: OFF_W] = OFF_W'(m_off[k]);
            pg_v[k*PG_W +: PG_W]    = PG_W'(m_pg[k]);
        end
        for (int p = 0; p < NPAGE; p++) page_v[p*PTR_W +: PTR_W] = m_ptr[p];
    end

    iso_rec_sel dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .uframe_i(uframe),
        .rec_active_i(act_v), .rec_len_i(len_v), .rec_off_i(off_v),
        .rec_pg_i(pg_v), .page_ptr_i(page_v), .max_pkt_i(mps),
        .ep_i(ep), .dev_i(dev), .dir_in_i(dir_in), .done_i(done),
        .done_bytes_i(dbytes), .done_err_i(derr), .busy_o(busy),
        .exec_o(exec_s), .exec_addr_o(addr), .exec_len_o(xlen),
        .tok_ep_o(tep), .tok_dev_o(tdev), .dir_in_o(dir_o),
        .page_err_o(pg_err), .wb_o(wb), .wb_idx_o(wb_idx),
        .wb_len_o(wb_len), .wb_status_o(wb_st)
    );

    typedef struct {
        int    kind;
        logic [63:0] val;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_run = 0;
    int   n_fail = 0;
    logic mb_busy = 1'b0;
    int   mb_idx = 0;
    int   mb_len = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] a, input logic [63:0] e);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, a, e);
        end
    endtask

    function automatic logic [63:0] pack_exec(logic [ADDR_W-1:0] a, logic [LEN_W-1:0] l,
                                              logic [EP_W-1:0] e, logic [DEV_W-1:0] d, logic di);
        return {8'd0, di, d, e, l, a};
    endfunction

    function automatic logic [63:0] pack_wb(logic [IDX_W-1:0] i, logic [LEN_W-1:0] l,
                                            logic [STAT_W-1:0] s);
        return {45'd0, i, l, s};
    endfunction

    // driver: start pulse, pushes what the requirements predict
    task automatic do_start(input int uf, input string req);
        exp_t e;
        @(posedge clk); #1;
        uframe = IDX_W'(uf);
        start  = 1'b1;
        if (!mb_busy && m_act[uf]) begin
            if (m_pg[uf] > 6) begin
                e.kind = 1; e.val = 64'd1; e.req = {req, " R8"};
                exp_q.push_back(e);
            end else begin
                int cl;
                cl = (m_len[uf] < int'(mps)) ? m_len[uf] : int'(mps);
                e.kind = 0;
                e.val  = pack_exec({m_ptr[m_pg[uf]], OFF_W'(m_off[uf])}, LEN_W'(cl), ep, dev, dir_in);
                e.req  = {req, " R1 R3 R4 R5"};
                exp_q.push_back(e);
                mb_busy = 1'b1; mb_idx = uf; mb_len = m_len[uf];
            end
        end
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic do_done(input int bytes, input int err, input string req);
        exp_t e;
        @(posedge clk); #1;
        done = 1'b1; dbytes = LEN_W'(bytes); derr = ERR_W'(err);
        if (mb_busy) begin
            e.kind = 2;
            e.val  = pack_wb(IDX_W'(mb_idx), LEN_W'((bytes >= mb_len) ? 0 : mb_len - bytes),
                             {ERR_W'(err), 1'b0});
            e.req  = {req, " R6 R7"};
            exp_q.push_back(e);
            mb_busy = 1'b0;
        end
        @(posedge clk); #1;
        done = 1'b0;
    endtask

    // monitor: pops one expected item per output pulse
    always @(negedge clk) begin
        if (rst_n && (exec_s || pg_err || wb)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected pulse", {61'd0, exec_s, pg_err, wb}, 64'd0);
            end else begin
                exp_t e;
                logic [63:0] a;
                int k;
                e = exp_q.pop_front();
                k = exec_s ? 0 : (pg_err ? 1 : 2);
                if (k == 0)      a = pack_exec(addr, xlen, tep, tdev, dir_o);
                else if (k == 1) a = 64'd1;
                else             a = pack_wb(wb_idx, wb_len, wb_st);
                chk(k == e.kind, {e.req, " R10 kind"}, 64'(k), 64'(e.kind));
                chk(a == e.val, e.req, a, e.val);
            end
        end
    end

    task automatic idle_chk(input string req);
        @(negedge clk);
        chk(busy == mb_busy, req, 64'(busy), 64'(mb_busy));
    endtask

    initial begin
        for (int k = 0; k < NREC; k++) begin
            m_act[k] = 1'b1;
            m_len[k] = 100 + 37 * k;
            m_off[k] = 12'h010 + 12'h111 * k;
            m_pg[k]  = k % NPAGE;
        end
        for (int p = 0; p < NPAGE; p++) m_ptr[p] = PTR_W'(32'h0A000 + 32'h1357 * p);

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !exec_s && !wb && !pg_err, "R10 reset state",
            {60'd0, busy, exec_s, wb, pg_err}, 64'd0);
        rst_n = 1'b1;

        // record 2, partial completion with error flags
        do_start(2, "uf2");
        idle_chk("R10 busy after exec");
        do_done(40, 3'b101, "uf2 done");
        idle_chk("R10 idle after wb");

        // length clipped to max packet, OUT direction
        mps = 11'd64; dir_in = 1'b0; ep = 4'hC; dev = 7'h7F;
        do_start(5, "R4 clip");
        do_done(4000, 0, "R6 floor");
        mps = 11'd1024; dir_in = 1'b1;

        // inactive record: no pulse, still idle
        m_act[3] = 1'b0;
        do_start(3, "R2 inactive");
        idle_chk("R2 inactive stays idle");
        m_act[3] = 1'b1;

        // page select out of range
        m_pg[6] = 7;
        do_start(6, "R8 bad page");
        idle_chk("R8 bad page stays idle");
        m_pg[6] = 6;

        // start while busy ignored; completion goes to first record
        do_start(1, "R9 first");
        do_start(4, "R9 second ignored");
        idle_chk("R9 still busy");
        do_done(20, 3'b010, "R9 wb first record");
        // completion while idle ignored
        do_done(5, 3'b111, "R9 idle done");
        idle_chk("R9 idle done ignored");

        // sweep all micro-frames, varied lengths
        for (int u = 0; u < NREC; u++) begin
            m_len[u] = (u == 0) ? 0 : 300 * u;
            m_off[u] = 12'hFFF - u;
            ep = 4'(u); dev = 7'(u * 9);
            do_start(u, "R1 sweep");
            do_done(250, u % 8, "R1 sweep done");
        end

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R10 all items seen", 64'(exp_q.size()), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #50000;
        n_fail++;
        n_run++;
        $display("FAIL R10 watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule